// File: doc/BRIEF.md
# Protected GPIO Pin-Function Controller

This block is the register file and pad-control logic for a bank of 8-pin GPIO ports. Software reaches it over a simple single-cycle register bus. For every pin it keeps a 2-bit direction code, an output data bit and a mode bit. The mode bit hands the pin either to GPIO or to a peripheral. Each pin also has a byte-wide function selector that names which peripheral signal the pin carries. Pad input levels pass through a two-flop synchronizer and can be read back per port.

The function selectors are guarded by a write-protect register with two bits: a lock bit (bit 7) and a selector write-enable bit (bit 6). The write-enable bit can change only while the lock bit is already clear. Software therefore opens the selectors with two writes, 0x00 and then 0x40, and closes them with 0x00 and then 0x80. The safe order for changing a pin's function is:

1. Park the pin in the Hi-Z direction code.
2. Drop its mode bit to GPIO.
3. Unlock the write-protect register.
4. Write the selector.
5. Relock.
6. Raise the mode bit.

The block drives per-pin output enable, input-buffer enable, output value, peripheral select and the selector bytes toward the pad ring.

Top module: `pmx_ctrl`

## Requirements
- R1: After reset every direction code, output data bit, mode bit and function selector is 0, all pad enables are low, and the write-protect register reads 0x0080 (locked, selector writes disabled).
- R2: Port p's direction register is a 16-bit word at offset 2*p. Pin n owns bits [2n+1:2n]. Code 00 is Hi-Z non-use, 10 is input, 11 is output, and 01 behaves as Hi-Z. Writes store all 16 bits and reads return them.
- R3: `pad_oe` for a pin is high only when its mode bit is 0 and its direction code is 11. It is updated one clock after the register that feeds it. `pad_do` carries the pin's output data bit.
- R4: `pad_ie` for a pin is high when its direction code is 10 or 11, and low for 00 and 01.
- R5: Port p's output data register sits at byte offset 0x040+p. It keeps wdata[7:0] and reads back zero-extended.
- R6: Port p's input data sits at offset 0x060+p and returns pad levels through two synchronizer flops. A read issued in the cycle right after a pad change still returns the old level, and a later read returns the new one.
- R7: Port p's mode register sits at offset 0x080+p, with 1 meaning peripheral. `pad_psel` mirrors it, and a set mode bit forces `pad_oe` low.
- R8: Pin n of port p has its function selector at offset 0x200+8*p+n. A write there is dropped unless the write-enable bit is 1, and reads always return the stored byte.
- R9: The write-protect register is at offset 0x2FF and reads {lock, enable, 000000}. A write always loads the lock bit from bit 7. It loads the enable bit from bit 6 only if the lock bit was 0 before that write.
- R10: The sequence 0x00, 0x40 enables selector writes, and 0x00, 0x80 disables them again.
- R11: Unmapped offsets read 0 and ignore writes. This covers odd direction offsets, port indices at or above the port count, and gaps between regions.
- R12: Every request is acknowledged exactly one cycle later, with read data valid in that cycle. No acknowledge appears without a request.
- R13: `pad_func` carries every pin's stored selector byte at bits [8*(8p+n)+7 : 8*(8p+n)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| bus_ack | output | 1 | Access complete, one cycle after the request |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| pad_di | input | NUM_PINS (176) | Pad input levels |
| pad_do | output | NUM_PINS (176) | Output value per pin |
| pad_oe | output | NUM_PINS (176) | Output-driver enable per pin |
| pad_ie | output | NUM_PINS (176) | Input-buffer enable per pin |
| pad_psel | output | NUM_PINS (176) | 1 = pin handed to a peripheral |
| pad_func | output | 8*NUM_PINS (1408) | Function selector byte per pin |

## Verification
The unlock logic is exercised with several write orders. The correct two-step unlock and relock show that selectors open and close. A single 0x40 write from the locked state separates "lock cleared" from "enable set", and a write with both bits set shows that the enable bit tracks the lock's old value rather than its new one. Direction patterns that mix all four codes in one word check the output-enable and input-enable decode per pin, and a mode write then confirms that peripheral hand-off overrides the driver. Pad input reads issued one and two cycles after a change tell a two-flop path apart from a shorter one, and probes of gap, odd and out-of-range offsets confirm that no address aliases into a real register.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int ADDR_W        = 12;
  localparam int DATA_W        = 16;
  localparam int PORT_IDX_W    = 5;   // supports up to 31 ports
  localparam int PIN_IDX_W     = PORT_IDX_W + 3;

  localparam logic [ADDR_W-1:0] DIR_BASE   = 12'h000;
  localparam logic [ADDR_W-1:0] ODR_BASE   = 12'h040;
  localparam logic [ADDR_W-1:0] IDR_BASE   = 12'h060;
  localparam logic [ADDR_W-1:0] MODE_BASE  = 12'h080;
  localparam logic [ADDR_W-1:0] FSEL_BASE  = 12'h200;
  localparam logic [ADDR_W-1:0] WPROT_ADDR = 12'h2FF;

  // Direction codes per pin
  localparam logic [1:0] DIR_HIZ = 2'b00;
  localparam logic [1:0] DIR_IN  = 2'b10;
  localparam logic [1:0] DIR_OUT = 2'b11;

  typedef enum logic [2:0] {
    RG_NONE, RG_DIR, RG_ODR, RG_IDR, RG_MODE, RG_FSEL, RG_WPROT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e             kind;
    logic [PORT_IDX_W-1:0] port;
    logic [2:0]            pin;
  } reg_sel_t;
endpackage

// File: rtl/pmx_addr_decode.sv
module pmx_addr_decode
  import pmx_pkg::*;
#(
  parameter int NUM_PORTS = 22
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam logic [ADDR_W-1:0] DIR_END  = ADDR_W'(DIR_BASE + 2 * NUM_PORTS);
  localparam logic [ADDR_W-1:0] ODR_END  = ADDR_W'(ODR_BASE + NUM_PORTS);
  localparam logic [ADDR_W-1:0] IDR_END  = ADDR_W'(IDR_BASE + NUM_PORTS);
  localparam logic [ADDR_W-1:0] MODE_END = ADDR_W'(MODE_BASE + NUM_PORTS);
  localparam logic [ADDR_W-1:0] FSEL_END = ADDR_W'(FSEL_BASE + PINS_PER_PORT * NUM_PORTS);

  logic [ADDR_W-1:0] dir_off, odr_off, idr_off, mode_off, fsel_off;

  assign dir_off  = addr - DIR_BASE;
  assign odr_off  = addr - ODR_BASE;
  assign idr_off  = addr - IDR_BASE;
  assign mode_off = addr - MODE_BASE;
  assign fsel_off = addr - FSEL_BASE;

  always_comb begin
    sel.kind = RG_NONE;
    sel.port = '0;
    sel.pin  = addr[2:0];
    // direction region starts at offset zero, so only the upper bound is tested
    if (addr < DIR_END && !addr[0]) begin
      sel.kind = RG_DIR;
      sel.port = PORT_IDX_W'(dir_off >> 1);
    end else if (addr >= ODR_BASE && addr < ODR_END) begin
      sel.kind = RG_ODR;
      sel.port = PORT_IDX_W'(odr_off);
    end else if (addr >= IDR_BASE && addr < IDR_END) begin
      sel.kind = RG_IDR;
      sel.port = PORT_IDX_W'(idr_off);
    end else if (addr >= MODE_BASE && addr < MODE_END) begin
      sel.kind = RG_MODE;
      sel.port = PORT_IDX_W'(mode_off);
    end else if (addr >= FSEL_BASE && addr < FSEL_END) begin
      sel.kind = RG_FSEL;
      sel.port = PORT_IDX_W'(fsel_off >> 3);
    end else if (addr == WPROT_ADDR) begin
      sel.kind = RG_WPROT;
    end
  end
endmodule

// File: rtl/pmx_wprot.sv
module pmx_wprot (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wdata_hi,  // {lock, enable} = write data bits 7:6
  output logic       lock,
  output logic       wen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock <= 1'b1;
      wen  <= 1'b0;
    end else if (wr_en) begin
      lock <= wdata_hi[1];
      // enable follows the write only while the lock was already open
      if (!lock) wen <= wdata_hi[0];
    end
  end
endmodule

// File: rtl/pmx_port_bank.sv
module pmx_port_bank
  import pmx_pkg::*;
#(
  parameter int NUM_PORTS = 22
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  reg_kind_e                              kind,
  input  logic [PORT_IDX_W-1:0]                  port,
  input  logic [DATA_W-1:0]                      wdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]     pad_di,
  output logic [2*NUM_PORTS*PINS_PER_PORT-1:0]   dir_flat,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]     odr_flat,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]     mode_flat,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]     idr_flat
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0]        dir_q;
    logic [PINS_PER_PORT-1:0] odr_q;
    logic [PINS_PER_PORT-1:0] mode_q;
    logic                     hit;

    assign hit = wr_en && (port == PORT_IDX_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q  <= '0;
        odr_q  <= '0;
        mode_q <= '0;
      end else begin
        if (hit && kind == RG_DIR)  dir_q  <= wdata;
        if (hit && kind == RG_ODR)  odr_q  <= wdata[PINS_PER_PORT-1:0];
        if (hit && kind == RG_MODE) mode_q <= wdata[PINS_PER_PORT-1:0];
      end
    end

    assign dir_flat [DATA_W*p +: DATA_W]               = dir_q;
    assign odr_flat [PINS_PER_PORT*p +: PINS_PER_PORT] = odr_q;
    assign mode_flat[PINS_PER_PORT*p +: PINS_PER_PORT] = mode_q;
  end

  // two-flop synchronizer on every pad input
  logic [NUM_PINS-1:0] meta_q, sync_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_di;
      sync_q <= meta_q;
    end
  end
  assign idr_flat = sync_q;
endmodule

// File: rtl/pmx_fsel_bank.sv
module pmx_fsel_bank
  import pmx_pkg::*;
#(
  parameter int NUM_PORTS = 22
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [PIN_IDX_W-1:0]                 idx,
  input  logic [7:0]                           wdata,
  output logic [8*NUM_PORTS*PINS_PER_PORT-1:0] fsel_flat
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [7:0] fsel_q;
    always_ff @(posedge clk) begin
      if (rst)                                     fsel_q <= '0;
      else if (wr_en && idx == PIN_IDX_W'(i))      fsel_q <= wdata;
    end
    assign fsel_flat[8*i +: 8] = fsel_q;
  end
endmodule

// File: rtl/pmx_pad_drive.sv
module pmx_pad_drive
  import pmx_pkg::*;
#(
  parameter int NUM_PINS = 176
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_PINS-1:0] dir_flat,
  input  logic [NUM_PINS-1:0]   mode_flat,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_ie
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] code;
    assign code = dir_flat[2*i +: 2];
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i] <= 1'b0;
        pad_ie[i] <= 1'b0;
      end else begin
        pad_oe[i] <= !mode_flat[i] && (code == DIR_OUT);
        pad_ie[i] <= (code == DIR_IN) || (code == DIR_OUT);
      end
    end
  end
endmodule

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
#(
  parameter int NUM_PORTS = 22
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 bus_req,
  input  logic                                 bus_we,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [DATA_W-1:0]                    bus_wdata,
  output logic                                 bus_ack,
  output logic [DATA_W-1:0]                    bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_di,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_do,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_oe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_ie,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pad_psel,
  output logic [8*NUM_PORTS*PINS_PER_PORT-1:0] pad_func
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  reg_sel_t              sel;
  logic                  wr_en;
  logic                  wp_lock, wp_wen;
  logic [2*NUM_PINS-1:0] dir_flat;
  logic [NUM_PINS-1:0]   odr_flat, mode_flat, idr_flat;
  logic [8*NUM_PINS-1:0] fsel_flat;
  logic [PIN_IDX_W-1:0]  pin_idx;
  logic [DATA_W-1:0]     rd_mux;

  assign wr_en   = bus_req && bus_we;
  assign pin_idx = {sel.port, sel.pin};

  pmx_addr_decode #(.NUM_PORTS(NUM_PORTS)) dec_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  pmx_wprot wprot_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en && sel.kind == RG_WPROT),
    .wdata_hi (bus_wdata[7:6]),
    .lock     (wp_lock),
    .wen      (wp_wen)
  );

  pmx_port_bank #(.NUM_PORTS(NUM_PORTS)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .kind      (sel.kind),
    .port      (sel.port),
    .wdata     (bus_wdata),
    .pad_di    (pad_di),
    .dir_flat  (dir_flat),
    .odr_flat  (odr_flat),
    .mode_flat (mode_flat),
    .idr_flat  (idr_flat)
  );

  pmx_fsel_bank #(.NUM_PORTS(NUM_PORTS)) fsel_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en && sel.kind == RG_FSEL && wp_wen),
    .idx       (pin_idx),
    .wdata     (bus_wdata[7:0]),
    .fsel_flat (fsel_flat)
  );

  pmx_pad_drive #(.NUM_PINS(NUM_PINS)) pad_i (
    .clk       (clk),
    .rst       (rst),
    .dir_flat  (dir_flat),
    .mode_flat (mode_flat),
    .pad_oe    (pad_oe),
    .pad_ie    (pad_ie)
  );

  always_comb begin
    rd_mux = '0;
    case (sel.kind)
      RG_DIR:   rd_mux = dir_flat[DATA_W*sel.port +: DATA_W];
      RG_ODR:   rd_mux = {8'h00, odr_flat [PINS_PER_PORT*sel.port +: PINS_PER_PORT]};
      RG_IDR:   rd_mux = {8'h00, idr_flat [PINS_PER_PORT*sel.port +: PINS_PER_PORT]};
      RG_MODE:  rd_mux = {8'h00, mode_flat[PINS_PER_PORT*sel.port +: PINS_PER_PORT]};
      RG_FSEL:  rd_mux = {8'h00, fsel_flat[8*pin_idx +: 8]};
      RG_WPROT: rd_mux = {8'h00, wp_lock, wp_wen, 6'b000000};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= (bus_req && !bus_we) ? rd_mux : '0;
    end
  end

  assign pad_do   = odr_flat;
  assign pad_psel = mode_flat;
  assign pad_func = fsel_flat;
endmodule

// File: rtl/pmx_ctrl_chk.sv
module pmx_ctrl_chk #(
  parameter int NUM_PINS = 176
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_req,
  input logic                  bus_ack,
  input logic                  wp_lock,
  input logic                  wp_wen,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_ie,
  input logic [NUM_PINS-1:0]   pad_psel,
  input logic [8*NUM_PINS-1:0] pad_func
);
  // R1
  reset_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wp_lock && !wp_wen));

  // R12
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);

  // R12
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ack);

  // R9
  wen_needs_open_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wp_wen) |-> !$past(wp_lock));

  // R8
  fsel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !wp_wen |=> $stable(pad_func));

  // R7
  oe_blocked_by_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & $past(pad_psel)) == '0);

  // R4
  oe_implies_ie_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~pad_ie) == '0);
endmodule

bind pmx_ctrl pmx_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .wp_lock  (wp_lock),
  .wp_wen   (wp_wen),
  .pad_oe   (pad_oe),
  .pad_ie   (pad_ie),
  .pad_psel (pad_psel),
  .pad_func (pad_func)
);

// File: tb/pmx_ctrl_tb_top.sv
module pmx_ctrl_tb_top;
  localparam int NUM_PORTS = 22;
  localparam int NUM_PINS  = NUM_PORTS * 8;
  localparam int NVEC      = 26;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0]           bus_addr = '0;
  logic [15:0]           bus_wdata = '0;
  logic                  bus_ack;
  logic [15:0]           bus_rdata;
  logic [NUM_PINS-1:0]   pad_di = '0;
  logic [NUM_PINS-1:0]   pad_do, pad_oe, pad_ie, pad_psel;
  logic [8*NUM_PINS-1:0] pad_func;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pmx_ctrl #(.NUM_PORTS(NUM_PORTS)) dut_i (
    .clk, .rst, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
    .pad_di, .pad_do, .pad_oe, .pad_ie, .pad_psel, .pad_func
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [15:0] wdata;
    logic [15:0] expv;
    logic [7:0]  req;
  } vec_t;

  // write rows: expv unused; read rows: wdata unused
  localparam logic [52:0] VECS [NVEC] = '{
    {1'b0, 12'h2FF, 16'h0000, 16'h0080, 8'd1},   // R1 locked at reset
    {1'b0, 12'h000, 16'h0000, 16'h0000, 8'd1},   // R1 direction clear
    {1'b1, 12'h000, 16'hE4B3, 16'h0000, 8'd2},
    {1'b0, 12'h000, 16'h0000, 16'hE4B3, 8'd2},   // R2 port 0
    {1'b1, 12'h02A, 16'h8001, 16'h0000, 8'd2},
    {1'b0, 12'h02A, 16'h0000, 16'h8001, 8'd2},   // R2 last port
    {1'b1, 12'h040, 16'h77A5, 16'h0000, 8'd5},
    {1'b0, 12'h040, 16'h0000, 16'h00A5, 8'd5},   // R5 upper byte dropped
    {1'b1, 12'h081, 16'h003C, 16'h0000, 8'd7},
    {1'b0, 12'h081, 16'h0000, 16'h003C, 8'd7},   // R7
    {1'b1, 12'h203, 16'h0011, 16'h0000, 8'd8},
    {1'b0, 12'h203, 16'h0000, 16'h0000, 8'd8},   // R8 locked write dropped
    {1'b1, 12'h2FF, 16'h0000, 16'h0000, 8'd9},
    {1'b0, 12'h2FF, 16'h0000, 16'h0000, 8'd9},   // R9 lock open, enable 0
    {1'b1, 12'h2FF, 16'h0040, 16'h0000, 8'd10},
    {1'b0, 12'h2FF, 16'h0000, 16'h0040, 8'd10},  // R10 unlocked
    {1'b1, 12'h203, 16'h0055, 16'h0000, 8'd10},
    {1'b0, 12'h203, 16'h0000, 16'h0055, 8'd10},  // R10 selector written
    {1'b1, 12'h2FF, 16'h0000, 16'h0000, 8'd10},
    {1'b1, 12'h2FF, 16'h0080, 16'h0000, 8'd10},
    {1'b0, 12'h2FF, 16'h0000, 16'h0080, 8'd10},  // R10 relocked
    {1'b1, 12'h203, 16'h00FF, 16'h0000, 8'd8},
    {1'b0, 12'h203, 16'h0000, 16'h0055, 8'd8},   // R8 held after relock
    {1'b1, 12'h03F, 16'h1234, 16'h0000, 8'd11},
    {1'b0, 12'h03F, 16'h0000, 16'h0000, 8'd11},  // R11 gap
    {1'b0, 12'h001, 16'h0000, 16'h0000, 8'd11}   // R11 odd direction offset
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic xfer(input logic we, input logic [11:0] a, input logic [15:0] d,
                      output logic [15:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check("R12 ack one cycle after request", 32'(bus_ack), 32'd1);
    rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    logic [15:0] unused_rd;
    xfer(1'b1, a, d, unused_rd);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [15:0] expv);
    logic [15:0] rd;
    xfer(1'b0, a, 16'h0000, rd);
    check(tag, 32'(rd), 32'(expv));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state at the pads
    check("R1 pad_oe clear",   32'(pad_oe   == '0), 32'd1);
    check("R1 pad_ie clear",   32'(pad_ie   == '0), 32'd1);
    check("R1 pad_psel clear", 32'(pad_psel == '0), 32'd1);
    check("R1 pad_func clear", 32'(pad_func == '0), 32'd1);
    check("R1 pad_do clear",   32'(pad_do   == '0), 32'd1);
    check("R12 idle no ack",   32'(bus_ack), 32'd0);
    rd_chk("R1 mode last port", 12'h095, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [15:0] rd;
      v = vec_t'(VECS[i]);
      xfer(v.we, v.addr, v.wdata, rd);
      if (!v.we) check($sformatf("R%0d vector %0d", v.req, i), 32'(rd), 32'(v.expv));
    end

    // R3 / R4: port 0 codes E4B3 -> pins 0,2,7 drive; 0,2,3,6,7 sense
    repeat (2) @(negedge clk);
    check("R3 pad_oe port0",  32'(pad_oe[7:0]),   32'h85);
    check("R4 pad_ie port0",  32'(pad_ie[7:0]),   32'hCD);
    check("R3 pad_do port0",  32'(pad_do[7:0]),   32'hA5);
    check("R3 pad_oe port21 code 01 no drive", 32'(pad_oe[175:168]), 32'h00);
    check("R4 pad_ie port21", 32'(pad_ie[175:168]), 32'h80);
    check("R7 pad_psel port1", 32'(pad_psel[15:8]), 32'h3C);
    check("R13 pad_func pin3", 32'(pad_func[31:24]), 32'h55);

    // R7 mode hand-off removes the driver
    wr(12'h080, 16'h0004);
    repeat (2) @(negedge clk);
    check("R7 pad_oe with mode bit", 32'(pad_oe[7:0]),   32'h81);
    check("R7 pad_psel port0",       32'(pad_psel[7:0]), 32'h04);
    check("R4 pad_ie unaffected by mode", 32'(pad_ie[7:0]), 32'hCD);

    // R4 back to Hi-Z
    wr(12'h000, 16'h0000);
    repeat (2) @(negedge clk);
    check("R4 Hi-Z ie", 32'(pad_ie[7:0]), 32'h00);
    check("R3 Hi-Z oe", 32'(pad_oe[7:0]), 32'h00);

    // R6 two-flop input path
    pad_di[15:8] = 8'h5A;
    rd_chk("R6 read one cycle after change is old", 12'h061, 16'h0000);
    rd_chk("R6 later read is new",                  12'h061, 16'h005A);

    // R9 single-step unlock from locked state
    wr(12'h2FF, 16'h0040);
    rd_chk("R9 one-step unlock leaves enable 0", 12'h2FF, 16'h0000);
    wr(12'h203, 16'h0077);
    rd_chk("R8 write refused while enable 0", 12'h203, 16'h0055);
    wr(12'h2FF, 16'h0040);
    rd_chk("R9 enable set with lock open", 12'h2FF, 16'h0040);
    wr(12'h2FF, 16'h00C0);
    rd_chk("R9 lock and enable together", 12'h2FF, 16'h00C0);
    wr(12'h2FF, 16'h0000);
    rd_chk("R9 enable held while lock was set", 12'h2FF, 16'h0040);
    wr(12'h2FF, 16'h0080);
    rd_chk("R9 relock clears enable", 12'h2FF, 16'h0080);

    // R11 out-of-range port and tail gap
    wr(12'h056, 16'h00FF);
    rd_chk("R11 port index past count", 12'h056, 16'h0000);
    rd_chk("R11 no alias into last port", 12'h055, 16'h0000);
    rd_chk("R11 past selector region", 12'h2B0, 16'h0000);
    @(negedge clk);
    check("R12 no ack when idle", 32'(bus_ack), 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule